// File: doc/BRIEF.md
# Handshaked Word-to-Bit Unpacker

The block takes parallel words from an upstream producer and hands them on one bit per cycle to a downstream consumer. Both sides use a valid/ready handshake. A transfer happens on a rising clock edge where valid and ready are both high. Each accepted word is sent as exactly `WORD_W` single-bit transfers, least significant bit first.

The downstream ready signal alone decides when the bit position moves. A stalled consumer therefore sees the same bit until it takes it. Ready-for-input rises combinationally in the cycle where the last bit of a word is taken. A waiting word is then loaded at that same edge, so the next word's bit 0 is valid one cycle later with no idle cycle between words.

The word is held in a register that rotates right by one place on each transfer. The output is always the register's bit 0, so no wide index multiplexer is needed.

Top module: `bit_unpacker`

## Requirements
- R1: Every accepted word produces exactly `WORD_W` output transfers. They carry word bit 0 first, then bits in ascending order up to bit `WORD_W-1`.
- R2: In a cycle where `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and `out_bit` unchanged.
- R3: When no word is loaded, `out_valid` is low. Cycles with `out_valid` low do not advance the bit position, whatever `out_ready` does. The next accepted word again starts at its bit 0.
- R4: `in_ready` is high in the cycle where the final bit of the current word is taken (`out_valid` and `out_ready` high on transfer `WORD_W-1`). With the consumer always ready, N back-to-back words finish in N*`WORD_W`+1 cycles, counted from the cycle that accepts the first word.
- R5: While a word is in flight, `in_ready` is low in every cycle except the one where its final bit is taken.
- R6: No accepted word is lost. Any sequence of words, under any consumer stall pattern, comes out complete and in acceptance order.
- R7: A synchronous active-high reset makes `out_valid` low and `in_ready` high in the following cycle, and discards any partly sent word.
- R8: When the block is idle, a word accepted at an edge makes `out_valid` high in the next cycle, with `out_bit` equal to that word's bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream word is valid |
| in_word | input | WORD_W | Upstream word |
| in_ready | output | 1 | Block can accept a word this cycle |
| out_valid | output | 1 | `out_bit` carries a valid bit |
| out_bit | output | 1 | Current serial bit |
| out_ready | input | 1 | Downstream takes the bit this cycle |

## Verification
A word accepted at an edge shows its bit 0 one cycle later. Each later bit appears one cycle after the edge where the previous bit was taken. `in_ready` is combinational, so it is valid in the same cycle as the final transfer.

The bench drives inputs at the falling edge and samples outputs shortly after it, so every sample sees the state left by the preceding rising edge. Each cycle it compares outputs against a model of what has been taken so far. A stall is checked one cycle later, against the bit recorded while stalled. The no-gap property is checked by counting the cycles of an unstalled run against the R4 total.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  localparam int unsigned DEFAULT_WORD_W = 64;

  // True when the transfer index is the final one of a word.
  function automatic logic is_final(input int unsigned idx, input int unsigned width);
    return idx == width - 1;
  endfunction

  // Next transfer index after a transfer that was not the final one.
  function automatic int unsigned next_index(input int unsigned idx);
    return idx + 1;
  endfunction
endpackage

// File: rtl/unpack_seq.sv
module unpack_seq
  import unpack_pkg::*;
#(
  parameter int unsigned WORD_W = DEFAULT_WORD_W
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic shift,
  output logic last_bit
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic             busy;
  logic [CNT_W-1:0] idx;

  // Named events used by the datapath and the assertions.
  assign shift     = busy & out_ready;
  assign last_bit  = shift & is_final(int'(idx), WORD_W);
  assign in_ready  = ~busy | last_bit;
  assign load      = in_valid & in_ready;
  assign out_valid = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (shift) begin
      idx <= CNT_W'(next_index(int'(idx)));
      if (last_bit) busy <= 1'b0;
    end
  end

  // R1: each non-final transfer moves the index on by exactly one.
  assert_index_step_R1: assert property (@(posedge clk) disable iff (rst)
    (shift && !last_bit && !load) |=> (int'(idx) == int'($past(idx)) + 1));

  // R3: with no word loaded and none arriving, the block stays idle.
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> !busy);

  // R5: while a word is in flight and its final bit is not being taken, no word is accepted.
  assert_block_input_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_bit) |-> !in_ready);

  // R7: reset empties the block by the next cycle.
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!busy && in_ready));
endmodule

// File: rtl/unpack_rotreg.sv
module unpack_rotreg
  import unpack_pkg::*;
#(
  parameter int unsigned WORD_W = DEFAULT_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] din,
  output logic              dout
);
  logic [WORD_W-1:0] data;

  // Rotate right and feed bit 0 back into the top, so the output is always bit 0.
  always_ff @(posedge clk) begin
    if (load)       data <= din;
    else if (shift) data <= {data[0], data[WORD_W-1:1]};
  end

  assign dout = data[0];

  // R1: after a rotation the output is the bit that sat one place above.
  assert_rotate_next_R1: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> (dout == $past(data[1])));

  // R8: after a load the output is bit 0 of the loaded word.
  assert_load_lsb_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> (dout == $past(din[0])));
endmodule

// File: rtl/bit_unpacker.sv
module bit_unpacker
  import unpack_pkg::*;
#(
  parameter int unsigned WORD_W = DEFAULT_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_bit,
  input  logic              out_ready
);
  logic load;
  logic shift;
  logic last_bit;

  unpack_seq #(.WORD_W(WORD_W)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .shift     (shift),
    .last_bit  (last_bit)
  );

  unpack_rotreg #(.WORD_W(WORD_W)) i_rot (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .shift (shift),
    .din   (in_word),
    .dout  (out_bit)
  );

  // R2: a stalled bit stays presented unchanged.
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R4: the final transfer of a word always opens the input.
  assert_final_opens_R4: assert property (@(posedge clk) disable iff (rst)
    last_bit |-> (in_ready && out_valid && out_ready));

  // R8: an accepted word is always presented in the next cycle.
  assert_load_valid_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> out_valid);
endmodule

// File: tb/test_bit_unpacker.sv
module test_bit_unpacker;
  localparam int unsigned WORD_W = 64;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 8;

  // Stimulus table: word and the consumer stall pattern used while it drains.
  // Pattern 0 always ready, 1 every other cycle, 2 stalls one cycle in three, 3 ready two cycles in five.
  localparam logic [WORD_W-1:0] VEC_WORD [NVEC] = '{
    64'hDEAD_BEEF_0123_4567, 64'h8000_0000_0000_0001, 64'hFFFF_0000_FFFF_0000,
    64'hA5A5_5A5A_C3C3_3C3C, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h1357_9BDF_2468_ACE0, 64'h7FFF_FFFF_FFFF_FFFE};
  localparam int VEC_MODE [NVEC] = '{0, 0, 0, 1, 2, 3, 0, 2};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [WORD_W-1:0] in_word = '0;
  logic              in_ready;
  logic              out_valid;
  logic              out_bit;
  logic              out_ready = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_unpacker #(.WORD_W(WORD_W)) i_bit_unpacker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit), .out_ready(out_ready));

  task automatic chk(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic ready_pat(input int mode, input int cyc);
    case (mode)
      1:       return (cyc % 2) == 0;
      2:       return (cyc % 3) != 2;
      3:       return (cyc % 5) < 2;
      default: return 1'b1;
    endcase
  endfunction

  // Streams table entries [first, first+count) with the producer always offering.
  // Returns the cycle count from the first acceptance to the final transfer.
  task automatic stream(input int first, input int count, output int cycles);
    int  widx = first;
    int  ridx = first;
    int  bitpos = 0;
    logic [WORD_W-1:0] got = '0;
    logic held = 1'b0;
    logic held_bit = 1'b0;
    int  start = -1;
    cycles = 0;
    for (int cyc = 0; cyc < 4000 && ridx < first + count; cyc++) begin
      @(negedge clk);
      #1;
      if (held) chk("R2 stalled bit held", {62'd0, out_valid, out_bit}, {62'd0, 1'b1, held_bit});
      in_valid  = widx < first + count;
      in_word   = (widx < first + count) ? VEC_WORD[widx] : '0;
      out_ready = ready_pat(VEC_MODE[ridx], cyc);
      #1;
      held     = out_valid && !out_ready;
      held_bit = out_bit;
      if (out_valid && !(out_ready && bitpos == WORD_W - 1) && in_ready) begin
        n_checks++; n_fail++;
        $display("FAIL R5 in_ready during word: actual 1 expected 0");
      end
      if (out_valid && out_ready) begin
        got[bitpos] = out_bit;
        if (bitpos == WORD_W - 1) begin
          chk("R4 in_ready on final bit", {63'd0, in_ready}, 64'd1);
          chk("R1 R6 word delivered in order", got, VEC_WORD[ridx]);
          ridx++;
          bitpos = 0;
          got = '0;
          if (ridx == first + count) cycles = cyc - start + 1;
        end else begin
          bitpos++;
        end
      end
      if (in_valid && in_ready) begin
        if (start < 0) start = cyc;
        widx++;
      end
    end
    if (ridx != first + count) begin
      n_checks++; n_fail++;
      $display("FAIL R6 words received: actual %0d expected %0d", ridx - first, count);
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc_used;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R7 reset state", {62'd0, out_valid, in_ready}, {62'd0, 1'b0, 1'b1});

    // Table walk: unstalled back-to-back run, then mixed stall patterns.
    stream(0, 3, cyc_used);
    chk("R4 no gap between words", 64'(cyc_used), 64'(3 * WORD_W + 1));
    stream(3, 5, cyc_used);

    // R3: idle with consumer ready must not advance anything.
    @(negedge clk);
    out_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1;
      chk("R3 out_valid low while idle", {63'd0, out_valid}, 64'd0);
    end

    // R8: load from idle, bit 0 visible one cycle later.
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_word = 64'h0000_0000_0000_0003;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R8 out_valid after load", {63'd0, out_valid}, 64'd1);
    chk("R8 R3 first bit is bit 0", {63'd0, out_bit}, 64'd1);

    // Take two bits (1,1), then bit 2 must be 0.
    out_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk("R1 third bit", {63'd0, out_bit}, 64'd0);

    // R7: reset mid-word discards it; next word starts at its bit 0.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R7 reset mid-word", {62'd0, out_valid, in_ready}, {62'd0, 1'b0, 1'b1});
    stream(7, 1, cyc_used);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule